// File: doc/BRIEF.md
# Isochronous Bus Cycle Timer with Cycle-Master Request

This block keeps the node's free-running isochronous time. The time is split into three fields that carry into one another: a sub-cycle offset ticking once per clock, a cycle number, and a seconds field. It runs in one of two roles. As cycle master, every cycle boundary raises a request for a cycle-start packet towards the transmit side. That request is held until the transmitter acknowledges it. In the slave role, each cycle-start packet received from the bus overwrites the local time with the value the packet carries, so the node stays in step with the master. Bus resets do not touch the timer. Only the block reset clears it.

The cycle boundary has two possible sources, picked by a select input. The first is an internal divider: the wrap of the offset field. The second is an external 8 kHz reference. That reference passes through a synchroniser and an edge detector, and in that mode the offset field is held at zero. Inside, a synchroniser, a field counter and a two-state request machine are chained. The machine's states are `REQ_IDLE` and `REQ_PENDING`. The transition `REQ_IDLE -> REQ_PENDING` happens on a boundary while the master role is enabled. The transition `REQ_PENDING -> REQ_IDLE` happens on an acknowledge. Every other case keeps the machine where it is. The counter picks one update kind per clock: `UPD_RELOAD`, `UPD_EXT_EDGE`, `UPD_EXT_IDLE` or `UPD_COUNT`.

Top module: `cycle_timer_top`

## Requirements
- R1: While reset is asserted and on release, the timer value is zero and the cycle-start request and cycle-tick outputs are low.
- R2: In internal mode the offset field rises by one on each clock from 0 to OFF_LIMIT-1. From OFF_LIMIT-1 it returns to 0 and the cycle field advances.
- R3: The cycle field counts 0 to CYC_LIMIT-1. On wrapping it advances the seconds field, and the seconds field wraps modulo 2^SEC_W. The timer output packs the fields as {seconds, cycle, offset}, with the offset in the least significant bits.
- R4: In internal mode, `cycle_tick_o` is high for exactly one clock. That clock is the one in which the timer first shows offset 0 after a wrap.
- R5: With the master role enabled, a cycle tick makes `start_req_o` high from the next clock. The request goes low in the clock after `start_ack` is sampled high while the request is high.
- R6: At most one request is outstanding. The request stays high until it is acknowledged, and ticks that come while it is high add nothing. After the acknowledge it stays low until a later tick.
- R7: With the master role disabled, `start_req_o` never rises.
- R8: With the master role disabled, a high `rx_start_valid` makes the timer equal `rx_start_time` after the next clock edge. This reload takes priority over the increment and over the external edge, and it produces no cycle tick.
- R9: With the master role enabled, `rx_start_valid` and `rx_start_time` have no effect on the timer.
- R10: In external mode the offset field is held at 0. The cycle field advances, with carry, and `cycle_tick_o` pulses on the third rising clock edge after `ref_8k` rises. That delay is two synchroniser flops plus an edge detector. A steady or falling reference changes nothing.
- R11: In internal mode the external reference has no effect on the timer or the ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock, nominally 24.576 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = cycle-master role, 0 = slave role |
| src_ext | input | 1 | 0 = internal divider, 1 = external 8 kHz reference |
| ref_8k | input | 1 | External 8 kHz reference, asynchronous |
| rx_start_valid | input | 1 | One-clock strobe: a cycle-start packet was received |
| rx_start_time | input | TIME_W | Time value carried by the received packet, packed {seconds, cycle, offset} |
| start_ack | input | 1 | Transmitter has taken the pending cycle-start request |
| timer_o | output | TIME_W | Current time, packed {seconds, cycle, offset} |
| start_req_o | output | 1 | Cycle-start request, held until acknowledged |
| cycle_tick_o | output | 1 | One-clock cycle-boundary pulse |

## Verification
The range assertions assume that a received time value holds an offset below OFF_LIMIT and a cycle number below CYC_LIMIT. The bench only ever loads such values. The single-pulse assertions rely on OFF_LIMIT being at least 2 and on the reference being slower than a few clocks per phase. The bench holds each reference level for at least three clocks. The source select and role inputs are treated as static over a clock and are changed only between steps. Away from the edge, the bench advances a reference model of the timer, the synchroniser and the request in step with the inputs it drives.

// File: rtl/cycle_timer_pkg.sv
`timescale 1ns/1ps
package cycle_timer_pkg;

    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_e;

    typedef enum logic [1:0] {
        UPD_RELOAD   = 2'd0,
        UPD_EXT_EDGE = 2'd1,
        UPD_EXT_IDLE = 2'd2,
        UPD_COUNT    = 2'd3
    } upd_kind_e;

endpackage

// File: rtl/cycle_ref_sync.sv
`timescale 1ns/1ps
module cycle_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    // chain[0..SYNC_STAGES-1] synchronise, chain[SYNC_STAGES] holds the previous level
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], ref_i};
        end
    end

    assign edge_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // R10: a detected edge lasts a single clock
    assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/cycle_field_counter.sv
`timescale 1ns/1ps
module cycle_field_counter
    import cycle_timer_pkg::*;
#(
    parameter int OFF_LIMIT = 3072,
    parameter int CYC_LIMIT = 8000,
    parameter int SEC_W     = 7,
    localparam int OFF_W    = $clog2(OFF_LIMIT),
    localparam int CYC_W    = $clog2(CYC_LIMIT),
    localparam int TIME_W   = SEC_W + CYC_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_i,
    input  logic              src_ext_i,
    input  logic              ext_edge_i,
    input  logic              rx_valid_i,
    input  logic [TIME_W-1:0] rx_time_i,
    output logic [TIME_W-1:0] time_o,
    output logic              tick_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LIMIT - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_LIMIT - 1);

    logic [OFF_W-1:0] off_q, off_d;
    logic [CYC_W-1:0] cyc_q, cyc_d;
    logic [SEC_W-1:0] sec_q, sec_d;
    logic             tick_q, tick_d;
    logic             bump;
    logic             reload;
    upd_kind_e        upd;

    assign reload = rx_valid_i & ~master_en_i;

    // pick the update kind for this clock; reload wins over everything
    always_comb begin
        if (reload) begin
            upd = UPD_RELOAD;
        end else if (src_ext_i) begin
            upd = ext_edge_i ? UPD_EXT_EDGE : UPD_EXT_IDLE;
        end else begin
            upd = UPD_COUNT;
        end
    end

    always_comb begin
        off_d  = off_q;
        bump   = 1'b0;
        tick_d = 1'b0;
        unique case (upd)
            UPD_RELOAD: begin
                off_d = rx_time_i[OFF_W-1:0];
            end
            UPD_EXT_EDGE: begin
                off_d  = '0;
                bump   = 1'b1;
                tick_d = 1'b1;
            end
            UPD_EXT_IDLE: begin
                off_d = '0;
            end
            UPD_COUNT: begin
                if (off_q == OFF_LAST) begin
                    off_d  = '0;
                    bump   = 1'b1;
                    tick_d = 1'b1;
                end else begin
                    off_d = off_q + 1'b1;
                end
            end
            default: begin
                off_d = off_q;
            end
        endcase
    end

    // cycle and seconds fields
    always_comb begin
        cyc_d = cyc_q;
        sec_d = sec_q;
        if (upd == UPD_RELOAD) begin
            cyc_d = rx_time_i[OFF_W +: CYC_W];
            sec_d = rx_time_i[OFF_W + CYC_W +: SEC_W];
        end else if (bump) begin
            if (cyc_q == CYC_LAST) begin
                cyc_d = '0;
                sec_d = sec_q + 1'b1;
            end else begin
                cyc_d = cyc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            cyc_q  <= '0;
            sec_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            off_q  <= off_d;
            cyc_q  <= cyc_d;
            sec_q  <= sec_d;
            tick_q <= tick_d;
        end
    end

    assign time_o = {sec_q, cyc_q, off_q};
    assign tick_o = tick_q;

    assert_offset_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(off_q) < OFF_LIMIT);

    assert_cycle_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cyc_q) < CYC_LIMIT);

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_reload_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !master_en_i) |=> (time_o == $past(rx_time_i) && !tick_o));

    assert_ext_offset_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && !reload) |=> (off_q == '0));

    assert_ext_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && !ext_edge_i && !reload) |=> $stable(cyc_q) && !tick_o);

endmodule

// File: rtl/cycle_start_fsm.sv
`timescale 1ns/1ps
module cycle_start_fsm
    import cycle_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en_i,
    input  logic tick_i,
    input  logic ack_i,
    output logic req_o
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:    if (tick_i && master_en_i) state_d = REQ_PENDING;
            REQ_PENDING: if (ack_i)                 state_d = REQ_IDLE;
            default:                                state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE:    req_o = 1'b0;
            REQ_PENDING: req_o = 1'b1;
            default:     req_o = 1'b0;
        endcase
    end

    assert_raise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && tick_i && master_en_i) |=> req_o);

    assert_release_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    assert_no_req_as_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !master_en_i) |=> !req_o);

endmodule

// File: rtl/cycle_timer_top.sv
`timescale 1ns/1ps
module cycle_timer_top #(
    parameter int OFF_LIMIT   = 3072,
    parameter int CYC_LIMIT   = 8000,
    parameter int SEC_W       = 7,
    parameter int SYNC_STAGES = 2,
    localparam int OFF_W      = $clog2(OFF_LIMIT),
    localparam int CYC_W      = $clog2(CYC_LIMIT),
    localparam int TIME_W     = SEC_W + CYC_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              src_ext,
    input  logic              ref_8k,
    input  logic              rx_start_valid,
    input  logic [TIME_W-1:0] rx_start_time,
    input  logic              start_ack,
    output logic [TIME_W-1:0] timer_o,
    output logic              start_req_o,
    output logic              cycle_tick_o
);
    logic ext_edge;
    logic tick;

    cycle_ref_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_8k),
        .edge_o (ext_edge)
    );

    cycle_field_counter #(
        .OFF_LIMIT (OFF_LIMIT),
        .CYC_LIMIT (CYC_LIMIT),
        .SEC_W     (SEC_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en_i (master_en),
        .src_ext_i   (src_ext),
        .ext_edge_i  (ext_edge),
        .rx_valid_i  (rx_start_valid),
        .rx_time_i   (rx_start_time),
        .time_o      (timer_o),
        .tick_o      (tick)
    );

    cycle_start_fsm u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en_i (master_en),
        .tick_i      (tick),
        .ack_i       (start_ack),
        .req_o       (start_req_o)
    );

    assign cycle_tick_o = tick;

endmodule

// File: tb/sim_cycle_timer_top.sv
`timescale 1ns/1ps
module sim_cycle_timer_top;
    localparam int OL = 8;
    localparam int CL = 5;
    localparam int SW = 3;
    localparam int OW = 3;
    localparam int CW = 3;
    localparam int TW = SW + CW + OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b0;
    logic          src_ext = 1'b0;
    logic          ref_8k = 1'b0;
    logic          rx_start_valid = 1'b0;
    logic [TW-1:0] rx_start_time = '0;
    logic          start_ack = 1'b0;
    logic [TW-1:0] timer_o;
    logic          start_req_o;
    logic          cycle_tick_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_off = 0, m_cyc = 0, m_sec = 0;
    bit m_tick = 0, m_req = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always #2.5 clk = ~clk;

    cycle_timer_top #(.OFF_LIMIT(OL), .CYC_LIMIT(CL), .SEC_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .src_ext(src_ext),
        .ref_8k(ref_8k), .rx_start_valid(rx_start_valid),
        .rx_start_time(rx_start_time), .start_ack(start_ack),
        .timer_o(timer_o), .start_req_o(start_req_o), .cycle_tick_o(cycle_tick_o)
    );

    function automatic logic [TW+1:0] expected();
        logic [TW-1:0] t;
        t = TW'((m_sec << (OW + CW)) | (m_cyc << OW) | m_off);
        return {t, m_tick, m_req};
    endfunction

    task automatic check(input string tag, input logic [TW+1:0] act, input logic [TW+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual time=%h tick=%b req=%b expected time=%h tick=%b req=%b",
                     tag, act[TW+1:2], act[1], act[0], exp[TW+1:2], exp[1], exp[0]);
        end
    endtask

    task automatic bump();
        if (m_cyc == CL - 1) begin
            m_cyc = 0;
            m_sec = (m_sec + 1) % (1 << SW);
        end else begin
            m_cyc++;
        end
    endtask

    // advance the model by one clock from the current inputs, then compare
    task automatic step(input string tag);
        bit tk;
        bit nt;
        tk = m_s2 && !m_s3;
        nt = 0;
        if (rx_start_valid && !master_en) begin
            m_off = int'(rx_start_time[OW-1:0]);
            m_cyc = int'(rx_start_time[OW +: CW]);
            m_sec = int'(rx_start_time[OW + CW +: SW]);
        end else if (src_ext) begin
            m_off = 0;
            if (tk) begin bump(); nt = 1; end
        end else begin
            if (m_off == OL - 1) begin m_off = 0; bump(); nt = 1; end
            else m_off++;
        end
        if (m_req) begin
            if (start_ack) m_req = 0;
        end else if (m_tick && master_en) begin
            m_req = 1;
        end
        m_tick = nt;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ref_8k;
        @(posedge clk); #1;
        check(tag, {timer_o, cycle_tick_o, start_req_o}, expected());
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", {timer_o, cycle_tick_o, start_req_o}, '0);
        rst_n = 1'b1;
        check("R1 on release", {timer_o, cycle_tick_o, start_req_o}, '0);

        // slave role, internal source, full sweep past the seconds wrap; reference toggles
        for (int i = 0; i < OL * CL * (1 << SW) + 12; i++) begin
            ref_8k = i[2];
            step("R2 R3 R4 R7 R11 sweep");
        end
        ref_8k = 1'b0;

        // master role: request held through several ticks, then acknowledged
        master_en = 1'b1;
        for (int i = 0; i < 3 * OL; i++) step("R5 R6 pending");
        start_ack = 1'b1;
        step("R5 ack");
        start_ack = 1'b0;
        for (int i = 0; i < OL + 2; i++) step("R6 after ack");
        start_ack = 1'b1;
        for (int i = 0; i < 2 * OL + 2; i++) step("R5 ack held high");
        start_ack = 1'b0;

        // master role ignores received times
        rx_start_time = {3'd5, 3'd2, 3'd1};
        rx_start_valid = 1'b1;
        for (int i = 0; i < 3; i++) step("R9 rx ignored");
        rx_start_valid = 1'b0;
        start_ack = 1'b1;
        step("R5 clear");
        start_ack = 1'b0;

        // slave reload at the offset wrap: priority over increment
        master_en = 1'b0;
        while (m_off != OL - 1) step("R8 align");
        rx_start_time = {3'd7, 3'd4, 3'd6};
        rx_start_valid = 1'b1;
        step("R8 reload at wrap");
        rx_start_valid = 1'b0;
        for (int i = 0; i < 4; i++) step("R3 R8 carry from reloaded");
        rx_start_time = {3'd0, 3'd0, 3'd2};
        rx_start_valid = 1'b1;
        step("R8 reload");
        rx_start_valid = 1'b0;
        for (int i = 0; i < 8; i++) step("R8 continue");

        // external reference, master role
        master_en = 1'b1;
        src_ext = 1'b1;
        for (int p = 0; p < 7; p++) begin
            ref_8k = 1'b0;
            for (int i = 0; i < 4; i++) step("R10 ref low");
            ref_8k = 1'b1;
            for (int i = 0; i < 5; i++) step("R10 ref rise");
            start_ack = p[0];
        end
        start_ack = 1'b1;
        ref_8k = 1'b0;
        step("R5 ext ack");
        start_ack = 1'b0;

        // external reference while slave, with reload overriding an edge
        master_en = 1'b0;
        for (int p = 0; p < 3; p++) begin
            ref_8k = 1'b0;
            for (int i = 0; i < 4; i++) step("R7 R10 ext slave");
            ref_8k = 1'b1;
            for (int i = 0; i < 4; i++) step("R7 R10 ext slave");
        end
        ref_8k = 1'b0;
        for (int i = 0; i < 3; i++) step("R10 ext settle");
        ref_8k = 1'b1;
        step("R8 pre");
        step("R8 pre");
        rx_start_time = {3'd3, 3'd1, 3'd5};
        rx_start_valid = 1'b1;
        step("R8 reload beats ext edge");
        rx_start_valid = 1'b0;
        for (int i = 0; i < 4; i++) step("R10 after reload");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule